// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the software-visible control state of one bus-master DMA channel. Software reaches it through a small byte-addressed register port. It writes a descriptor table address, sets a run bit to launch a transfer and clears that bit to cancel one. It polls or clears status flags through the same port. The block turns edges of the run bit into single-cycle requests toward a separate DMA engine. A launch request carries the descriptor address that was current when the run bit rose.

The attached device reports the end of a transfer with a one-cycle completion pulse. The block then stops the channel, drops the busy indication and raises a sticky interrupt flag, which software clears by writing a one to it. Address decoding above the channel and the DMA engine itself are outside this block.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset the status byte reads 0x60 (both capability bits, bit 5 and bit 6, are 1). Every other register bit reads 0, including the command byte and the 32-bit descriptor address.
- R2: The register image is eight bytes: command at byte 0, status at byte 2, descriptor address little-endian in bytes 4 to 7, and bytes 1 and 3 always 0. A read returns the image bytes starting at `reg_addr`, one, two or four of them for `reg_size` 0, 1 or 2 (3 is treated as 2). Bytes above the returned size, or past byte 7, read as 0.
- R3: A write changes state only in three cases: a single-byte write (size 0) to byte 0, a single-byte write to byte 2, or a four-byte write (size 2) to byte 4. Any other write leaves every register unchanged and produces no request.
- R4: Command byte: bit 0 is run and bit 3 is direction, and the other bits read 0. A command write leaves direction unchanged when run was already 1 before the write.
- R5: A command write that takes run from 0 to 1 sets status bit 0 (busy) in the same edge. `dma_start` pulses high for the following cycle, with `dma_ptr` equal to the descriptor address at the time of the write.
- R6: A command write that takes run from 1 to 0 clears busy and pulses `dma_abort` for the following cycle. A command write that leaves run unchanged issues no request, and the two requests never coincide.
- R7: Status bit 0 (busy) cannot be written. Status writes leave it unchanged.
- R8: Status bit 1 (error) and bit 2 (interrupt) are cleared by writing 1 and unchanged by writing 0. No write can set them.
- R9: The two lowest bits of the descriptor address are stored as 0 regardless of the written data.
- R10: A `dev_done` pulse clears run and busy and sets the interrupt bit, without issuing a request. It takes priority over a command write in the same cycle, whose run value is then discarded. It also takes priority over an interrupt clear in the same cycle.
- R11: Status bits 5 and 6 are plain read/write storage. Status bits 3, 4 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_addr | input | 3 | Byte offset within the register image |
| reg_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| reg_rdata | output | 32 | Read data for the current offset and size |
| dev_done | input | 1 | Transfer-complete pulse from the device |
| dma_start | output | 1 | One-cycle launch request |
| dma_abort | output | 1 | One-cycle cancel request |
| dma_ptr | output | 32 | Descriptor address latched at launch |

## Verification
The bound checker watches several relations on every cycle. Busy always equals run. A launch is always preceded by a write and sees run and busy set, while a cancel always sees both clear. Direction never moves while run stays high, the error flag stays clear, and a completion leaves the interrupt set and run clear. The bench scenarios cover the rest: the register image and read alignment, the rejection of wrongly sized writes, the exact address carried by each launch, write-one-to-clear against write-zero, and the priority of a completion over a command write or an interrupt clear landing in the same cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int REG_BYTES = 8;
    localparam int OFF_W     = $clog2(REG_BYTES);
    localparam int BUS_W     = 32;
    localparam int PTR_W     = 32;
    localparam int IMG_W     = 8 * REG_BYTES;

    localparam int OFF_CMD  = 0;
    localparam int OFF_STAT = 2;
    localparam int OFF_PTR  = 4;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;

    localparam int ST_BUSY_BIT = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_IRQ_BIT  = 2;
    localparam int ST_CAP0_BIT = 5;
    localparam int ST_CAP1_BIT = 6;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             run;
        logic             dir;
        logic             go;
        logic             stop;
        logic [PTR_W-1:0] launch_ptr;
    } cmd_state_t;

    typedef struct packed {
        logic       busy;
        logic       err;
        logic       irq;
        logic [1:0] cap;
    } stat_state_t;
endpackage

// File: rtl/bmdma_cmd_unit.sv
module bmdma_cmd_unit
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic             done,
    output logic [7:0]       cmd_byte,
    output logic             run_rise,
    output logic             run_fall,
    output logic             go_pulse,
    output logic             stop_pulse,
    output logic [PTR_W-1:0] go_ptr
);
    cmd_state_t cmd_d, cmd_q;
    logic       unused_bits;

    assign unused_bits = ^{wr_byte[7:4], wr_byte[2:1]};

    always_comb begin
        cmd_d      = cmd_q;
        cmd_d.go   = 1'b0;
        cmd_d.stop = 1'b0;
        run_rise   = 1'b0;
        run_fall   = 1'b0;
        if (wr_en) begin
            if (!cmd_q.run) begin
                cmd_d.dir = wr_byte[CMD_DIR_BIT];
            end
            if (!done) begin
                cmd_d.run = wr_byte[CMD_RUN_BIT];
                run_rise  = !cmd_q.run &&  wr_byte[CMD_RUN_BIT];
                run_fall  =  cmd_q.run && !wr_byte[CMD_RUN_BIT];
            end
        end
        if (done) begin
            cmd_d.run = 1'b0;
        end
        cmd_d.go   = run_rise;
        cmd_d.stop = run_fall;
        if (run_rise) begin
            cmd_d.launch_ptr = cur_ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    always_comb begin
        cmd_byte              = '0;
        cmd_byte[CMD_RUN_BIT] = cmd_q.run;
        cmd_byte[CMD_DIR_BIT] = cmd_q.dir;
    end

    assign go_pulse   = cmd_q.go;
    assign stop_pulse = cmd_q.stop;
    assign go_ptr     = cmd_q.launch_ptr;
endmodule

// File: rtl/bmdma_stat_unit.sv
module bmdma_stat_unit
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       busy_set,
    input  logic       busy_clr,
    input  logic       done,
    output logic [7:0] stat_byte
);
    stat_state_t stat_d, stat_q;
    logic        unused_bits;

    assign unused_bits = ^{wr_byte[7], wr_byte[4:3], wr_byte[0]};

    always_comb begin
        stat_d = stat_q;
        if (busy_set) begin
            stat_d.busy = 1'b1;
        end else if (busy_clr || done) begin
            stat_d.busy = 1'b0;
        end
        if (wr_en) begin
            if (wr_byte[ST_ERR_BIT]) begin
                stat_d.err = 1'b0;
            end
            if (wr_byte[ST_IRQ_BIT]) begin
                stat_d.irq = 1'b0;
            end
            stat_d.cap = {wr_byte[ST_CAP1_BIT], wr_byte[ST_CAP0_BIT]};
        end
        if (done) begin
            stat_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q     <= '0;
            stat_q.cap <= 2'b11;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_comb begin
        stat_byte              = '0;
        stat_byte[ST_BUSY_BIT] = stat_q.busy;
        stat_byte[ST_ERR_BIT]  = stat_q.err;
        stat_byte[ST_IRQ_BIT]  = stat_q.irq;
        stat_byte[ST_CAP0_BIT] = stat_q.cap[0];
        stat_byte[ST_CAP1_BIT] = stat_q.cap[1];
    end
endmodule

// File: rtl/bmdma_ptr_unit.sv
module bmdma_ptr_unit
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_word,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic             unused_bits;

    assign unused_bits = ^wr_word[1:0];

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            ptr_d = {wr_word[PTR_W-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
    import bmdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_size,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             dev_done,
    output logic             dma_start,
    output logic             dma_abort,
    output logic [PTR_W-1:0] dma_ptr
);
    logic             wr_cmd, wr_stat, wr_ptr;
    logic [7:0]       cmd_byte, stat_byte;
    logic [PTR_W-1:0] ptr_val;
    logic             run_rise, run_fall;
    logic [IMG_W-1:0] image, shifted;
    logic [BUS_W-1:0] size_mask;
    logic             unused_bits;

    assign wr_cmd  = reg_wr && (reg_addr == OFF_W'(OFF_CMD))  && (reg_size == ACC_BYTE);
    assign wr_stat = reg_wr && (reg_addr == OFF_W'(OFF_STAT)) && (reg_size == ACC_BYTE);
    assign wr_ptr  = reg_wr && (reg_addr == OFF_W'(OFF_PTR))  && (reg_size == ACC_WORD);

    bmdma_cmd_unit u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_cmd),
        .wr_byte    (reg_wdata[7:0]),
        .cur_ptr    (ptr_val),
        .done       (dev_done),
        .cmd_byte   (cmd_byte),
        .run_rise   (run_rise),
        .run_fall   (run_fall),
        .go_pulse   (dma_start),
        .stop_pulse (dma_abort),
        .go_ptr     (dma_ptr)
    );

    bmdma_stat_unit u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_stat),
        .wr_byte   (reg_wdata[7:0]),
        .busy_set  (run_rise),
        .busy_clr  (run_fall),
        .done      (dev_done),
        .stat_byte (stat_byte)
    );

    bmdma_ptr_unit u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ptr),
        .wr_word (reg_wdata[PTR_W-1:0]),
        .ptr     (ptr_val)
    );

    always_comb begin
        image                       = '0;
        image[8*OFF_CMD +: 8]       = cmd_byte;
        image[8*OFF_STAT +: 8]      = stat_byte;
        image[8*OFF_PTR +: PTR_W]   = ptr_val;
        shifted                     = image >> {reg_addr, 3'b000};
        case (reg_size)
            ACC_BYTE: size_mask = BUS_W'(32'h0000_00FF);
            ACC_HALF: size_mask = BUS_W'(32'h0000_FFFF);
            default:  size_mask = '1;
        endcase
        reg_rdata = shifted[BUS_W-1:0] & size_mask;
    end

    assign unused_bits = ^shifted[IMG_W-1:BUS_W];
endmodule

// File: rtl/bmdma_chan_regs_chk.sv
module bmdma_chan_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       dev_done,
    input logic       dma_start,
    input logic       dma_abort,
    input logic [1:0] ptr_lo,
    input logic [7:0] cmd_byte,
    input logic [7:0] stat_byte
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && dma_abort)); // R6

    AST_START_SEES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (stat_byte[0] && cmd_byte[0])); // R5

    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(reg_wr)); // R5

    AST_ABORT_SEES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_abort |-> (!stat_byte[0] && !cmd_byte[0])); // R6

    AST_BUSY_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[0] == cmd_byte[0]); // R7

    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_byte[0]) |-> (cmd_byte[3] == $past(cmd_byte[3]))); // R4

    AST_ERR_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_byte[1]); // R8

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        dev_done |=> (stat_byte[2] && !cmd_byte[0])); // R10

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (ptr_lo == 2'b00)); // R9
endmodule

bind bmdma_chan_regs bmdma_chan_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .dev_done  (dev_done),
    .dma_start (dma_start),
    .dma_abort (dma_abort),
    .ptr_lo    (dma_ptr[1:0]),
    .cmd_byte  (cmd_byte),
    .stat_byte (stat_byte)
);

// File: tb/tb_bmdma_chan_regs.sv
module tb_bmdma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_size;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        dev_done;
    logic        dma_start;
    logic        dma_abort;
    logic [31:0] dma_ptr;

    int checks = 0;
    int errors = 0;

    int          q_kind[$];
    logic [31:0] q_ptr[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    bmdma_chan_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_size  (reg_size),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_done  (dev_done),
        .dma_start (dma_start),
        .dma_abort (dma_abort),
        .dma_ptr   (dma_ptr)
    );

    // kind 1 = launch request, kind 2 = cancel request
    task automatic expect_req(input int kind, input logic [31:0] p, input string tag);
        q_kind.push_back(kind);
        q_ptr.push_back(p);
        q_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && (dma_start || dma_abort)) begin
            int          k;
            int          got;
            logic [31:0] p;
            string       t;
            got = dma_start ? 1 : 2;
            checks++;
            if (dma_start && dma_abort) begin
                errors++;
                $display("FAIL R6: both requests high, actual start=1 abort=1 expected one");
            end else if (q_kind.size() == 0) begin
                errors++;
                $display("FAIL R6: unexpected request kind %0d, expected none", got);
            end else begin
                k = q_kind.pop_front();
                p = q_ptr.pop_front();
                t = q_tag.pop_front();
                if (k != got) begin
                    errors++;
                    $display("FAIL %s: request kind actual %0d expected %0d", t, got, k);
                end else if (k == 1 && dma_ptr !== p) begin
                    errors++;
                    $display("FAIL %s: launch address actual %h expected %h", t, dma_ptr, p);
                end
            end
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [1:0] s,
                            input logic [31:0] d, input logic done);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_size  = s;
        reg_wdata = d;
        dev_done  = done;
        @(negedge clk);
        reg_wr   = 1'b0;
        dev_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        dev_done = 1'b1;
        @(negedge clk);
        dev_done = 1'b0;
    endtask

    task automatic check_rd(input logic [2:0] a, input logic [1:0] s,
                            input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        reg_size = s;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read at %0d size %0d actual %h expected %h",
                     tag, a, s, reg_rdata, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_size  = 2'd0;
        reg_addr  = 3'd0;
        reg_wdata = '0;
        dev_done  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image
        check_rd(3'd0, 2'd2, 32'h0060_0000, "R1");
        check_rd(3'd4, 2'd2, 32'h0000_0000, "R1");

        // R9 address alignment, R2 byte reads
        do_write(3'd4, 2'd2, 32'h1234_5677, 1'b0);
        check_rd(3'd4, 2'd2, 32'h1234_5674, "R9");
        check_rd(3'd5, 2'd0, 32'h0000_0056, "R2");
        check_rd(3'd4, 2'd0, 32'h0000_0074, "R2");

        // R3 wrongly sized writes are ignored
        do_write(3'd4, 2'd0, 32'h0000_00FF, 1'b0);
        check_rd(3'd4, 2'd2, 32'h1234_5674, "R3");
        do_write(3'd0, 2'd1, 32'h0000_0001, 1'b0);
        check_rd(3'd0, 2'd0, 32'h0000_0000, "R3");
        do_write(3'd2, 2'd1, 32'h0000_0000, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0060, "R3");

        // R4 direction written while idle
        do_write(3'd0, 2'd0, 32'h0000_0008, 1'b0);
        check_rd(3'd0, 2'd0, 32'h0000_0008, "R4");

        // R5 launch, other command bits read zero
        expect_req(1, 32'h1234_5674, "R5");
        do_write(3'd0, 2'd0, 32'h0000_00F9, 1'b0);
        check_rd(3'd0, 2'd0, 32'h0000_0009, "R4");
        check_rd(3'd2, 2'd0, 32'h0000_0061, "R5");

        // R4 direction frozen while running, R6 no request without edge
        do_write(3'd0, 2'd0, 32'h0000_0001, 1'b0);
        check_rd(3'd0, 2'd0, 32'h0000_0009, "R4");

        do_write(3'd4, 2'd2, 32'hAAAA_5553, 1'b0);

        // R7 busy not writable
        do_write(3'd2, 2'd0, 32'h0000_0060, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0061, "R7");

        // R6 cancel; direction still frozen by the running state before the write
        expect_req(2, 32'h0, "R6");
        do_write(3'd0, 2'd0, 32'h0000_0000, 1'b0);
        check_rd(3'd0, 2'd0, 32'h0000_0008, "R4");
        check_rd(3'd2, 2'd0, 32'h0000_0060, "R6");
        do_write(3'd0, 2'd0, 32'h0000_0000, 1'b0);
        check_rd(3'd0, 2'd0, 32'h0000_0000, "R4");

        // R8 software cannot set interrupt or error
        do_write(3'd2, 2'd0, 32'h0000_0066, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0060, "R8");

        // R10 completion
        expect_req(1, 32'hAAAA_5550, "R5");
        do_write(3'd0, 2'd0, 32'h0000_0001, 1'b0);
        pulse_done();
        check_rd(3'd0, 2'd0, 32'h0000_0000, "R10");
        check_rd(3'd2, 2'd0, 32'h0000_0064, "R10");

        // R8 write zero keeps, write one clears
        do_write(3'd2, 2'd0, 32'h0000_0060, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0064, "R8");
        do_write(3'd2, 2'd0, 32'h0000_0064, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0060, "R8");

        // R11 capability bits writable, reserved bits zero
        do_write(3'd2, 2'd0, 32'h0000_0020, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0020, "R11");
        do_write(3'd2, 2'd0, 32'h0000_00FF, 1'b0);
        check_rd(3'd2, 2'd0, 32'h0000_0060, "R11");

        // R10 completion beats a same-cycle cancel write and interrupt clear
        expect_req(1, 32'hAAAA_5550, "R5");
        do_write(3'd0, 2'd0, 32'h0000_0001, 1'b0);
        do_write(3'd0, 2'd0, 32'h0000_0000, 1'b1);
        check_rd(3'd0, 2'd0, 32'h0000_0000, "R10");
        check_rd(3'd2, 2'd0, 32'h0000_0064, "R10");
        do_write(3'd2, 2'd0, 32'h0000_0064, 1'b1);
        check_rd(3'd2, 2'd0, 32'h0000_0064, "R10");

        // R2 alignment and truncation past the image
        check_rd(3'd6, 2'd1, 32'h0000_AAAA, "R2");
        check_rd(3'd7, 2'd1, 32'h0000_00AA, "R2");
        check_rd(3'd2, 2'd2, 32'h5550_0064, "R2");

        repeat (3) @(negedge clk);
        checks++;
        if (q_kind.size() != 0) begin
            errors++;
            $display("FAIL R5: pending requests actual %0d expected 0", q_kind.size());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule